// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block models the column side of a single synchronous DRAM bank as seen from inside the device. It holds a small word array and accepts one command per clock edge: read, write, burst stop, or no operation. Each command carries a column address, a byte-lane-style mask bit (`dqm`) and a write word. Reads return data after a selectable latency of two or three cycles. Writes store one word per edge, starting with the word presented on the command edge. The burst length is taken from `bl_mode` when each read or write command arrives. Choices are 2, 4 or 8 words, or a whole page that wraps around.

A newer read or write command ends any burst in progress on the edge it arrives. Read words already in the latency pipeline still come out. A stop command ends the issue of further words. The output enable `rd_valid` stands in for the electrical output drivers. A host uses the block as a cycle-accurate memory target when testing a controller's column command scheduling. The host changes `cas_lat3` only while no read words are in flight.

Top module: `sdram_col_burst`

## Requirements
- R1: While `rst_n` is low and after it rises with only no-operation commands (`cmd` = 00), `rd_valid` is 0 and `rd_data` is 0.
- R2: A read command (`cmd` = 01) sampled on edge E presents its first word with `rd_valid` high after edge E+1 when `cas_lat3` = 0, or after edge E+2 when `cas_lat3` = 1. That word is captured on the second or third edge after E. Each later word of the burst follows one cycle after the previous one.
- R3: `bl_mode` sampled with the command sets the burst length: 00 gives 2 words, 01 gives 4, 10 gives 8, and 11 gives a full page of 2^COL_W words. A finite burst issues exactly that many words and then stops.
- R4: Word k of a burst of length L that starts at column S uses column (S with its low log2(L) bits cleared) OR ((S + k) mod L). The burst therefore stays inside its L-aligned block.
- R5: A write command (`cmd` = 10) stores `wdata` at `col` on the command edge. Each following edge of the burst stores that edge's `wdata` at the next burst column.
- R6: A read issued during a read burst stops the older burst issuing words on that edge. Older words already issued still appear, and the new burst's words follow with their own latency.
- R7: A write issued during a write burst ends the older burst. The new burst's first word is stored on the new command edge.
- R8: A read issued during a write burst discards the write words that would have followed. `wdata` presented from the read edge on is not stored.
- R9: In full-page mode the column wraps from 2^COL_W-1 to 0, and words continue until a stop or another command arrives.
- R10: A stop command (`cmd` = 11) during a read issues no further words. The last word delivered is the one issued on the edge before the stop, so output ends a latency's worth of cycles after the stop.
- R11: A stop command during a write stores nothing on the stop edge or afterwards, whatever `wdata` holds.
- R12: `dqm` high on edge E forces `rd_valid` low, and `rd_data` to 0, in the cycle after edge E+1.
- R13: `dqm` high on the edge that a write word is due prevents that word from being stored. The burst still advances past that column.
- R14: A write issued while read words are still in flight ends the read burst on that edge. Read words already issued still appear, and the write's first word is stored on its command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 00 no operation, 01 read, 10 write, 11 burst stop |
| col | input | COL_W | Start column for read or write commands |
| dqm | input | 1 | Mask: blanks read output two cycles later, blocks the current write word |
| wdata | input | DATA_W | Write word sampled on each write beat edge |
| bl_mode | input | 2 | Burst length select, sampled with read and write commands |
| cas_lat3 | input | 1 | 0 selects read latency 2, 1 selects read latency 3 |
| rd_data | output | DATA_W | Read word, 0 when not valid |
| rd_valid | output | 1 | Output enable for read data |

## Verification
The hardest overlap is an interrupting command on the same edge as unfinished older work. A new read, write or stop can arrive while older read words are still in the latency pipeline, or while a `dqm` mask is still pending. Directed sequences place the second command one edge after the first and place stops on chosen beats. A long random phase lets such overlaps and latency changes between idle periods occur in bulk. On every edge a scoreboard in the bench derives the expected `rd_valid` and `rd_data` from a reference array and from the burst rules. Read-back bursts expose any write word that should have been discarded or masked.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

    // Command codes seen on the cmd port
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_STOP  = 2'b11
    } col_cmd_e;

    // Burst length select
    typedef enum logic [1:0] {
        BL_TWO   = 2'b00,
        BL_FOUR  = 2'b01,
        BL_EIGHT = 2'b10,
        BL_PAGE  = 2'b11
    } burst_len_e;

endpackage

// File: rtl/sdram_col_addr.sv
module sdram_col_addr #(
    parameter int COL_W = 6
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] addr
);
    // Sequential order wrapping inside the aligned block chosen by mask
    always_comb begin
        addr = (start & ~mask) | ((start + idx) & mask);
    end
endmodule

// File: rtl/sdram_col_ctrl.sv
module sdram_col_ctrl
    import sdram_col_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  col_cmd_e         cmd,
    input  logic [COL_W-1:0] col,
    input  burst_len_e       bl_mode,
    output logic             issue_rd,
    output logic             issue_wr,
    output logic [COL_W-1:0] beat_addr
);
    typedef struct packed {
        logic             act;
        logic             wr;
        logic             page;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
    } burst_st_t;

    burst_st_t        st_d, st_q;
    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] mask_sel;

    always_comb begin
        case (bl_mode)
            BL_TWO:   mask_sel = COL_W'(1);
            BL_FOUR:  mask_sel = COL_W'(3);
            BL_EIGHT: mask_sel = COL_W'(7);
            default:  mask_sel = '1;
        endcase
    end

    sdram_col_addr #(.COL_W(COL_W)) u_addr (
        .start (st_q.start),
        .idx   (st_q.idx),
        .mask  (st_q.mask),
        .addr  (seq_addr)
    );

    always_comb begin
        st_d      = st_q;
        issue_rd  = 1'b0;
        issue_wr  = 1'b0;
        beat_addr = col;
        case (cmd)
            CMD_READ, CMD_WRITE: begin
                issue_rd   = (cmd == CMD_READ);
                issue_wr   = (cmd == CMD_WRITE);
                st_d.act   = 1'b1;
                st_d.wr    = (cmd == CMD_WRITE);
                st_d.page  = (bl_mode == BL_PAGE);
                st_d.start = col;
                st_d.mask  = mask_sel;
                st_d.idx   = COL_W'(1);
            end
            CMD_STOP: begin
                st_d.act = 1'b0;
            end
            default: begin
                if (st_q.act) begin
                    beat_addr = seq_addr;
                    issue_rd  = !st_q.wr;
                    issue_wr  = st_q.wr;
                    st_d.idx  = st_q.idx + COL_W'(1);
                    if (!st_q.page && (st_q.idx == st_q.mask)) begin
                        st_d.act = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    burst_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_NOP) && (issue_rd || issue_wr)) |->
            (((beat_addr ^ st_q.start) & ~st_q.mask) == '0));

    // R11
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |=> ((cmd != CMD_NOP) || (!issue_rd && !issue_wr)));
endmodule

// File: rtl/sdram_col_rd_pipe.sv
module sdram_col_rd_pipe #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              cas_lat3,
    input  logic              dqm,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CL_LO = 2;
    localparam int CL_HI = 3;

    typedef struct packed {
        logic [CL_HI-1:0]             vld;
        logic [CL_HI-1:0][DATA_W-1:0] dat;
        logic [1:0]                   dqm_dly;
    } pipe_st_t;

    pipe_st_t st_d, st_q;
    logic     tap_v;

    always_comb begin
        st_d.vld     = {st_q.vld[CL_HI-2:0], issue};
        st_d.dat     = {st_q.dat[CL_HI-2:0], rd_word};
        st_d.dqm_dly = {st_q.dqm_dly[0], dqm};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tap_v    = cas_lat3 ? st_q.vld[CL_HI-1] : st_q.vld[CL_LO-1];
        rd_valid = tap_v && !st_q.dqm_dly[1];
        rd_data  = '0;
        if (rd_valid) rd_data = cas_lat3 ? st_q.dat[CL_HI-1] : st_q.dat[CL_LO-1];
    end

    // R2
    lat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cas_lat3) |-> $past(issue, 2));

    // R2
    lat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cas_lat3) |-> $past(issue, 3));

    // R12
    dqm_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dqm, 2) |-> !rd_valid);
endmodule

// File: rtl/sdram_col_mem.sv
module sdram_col_mem #(
    parameter int DATA_W = 16,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [COL_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/sdram_col_burst.sv
module sdram_col_burst
    import sdram_col_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [COL_W-1:0]  col,
    input  logic              dqm,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        bl_mode,
    input  logic              cas_lat3,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              issue_rd;
    logic              issue_wr;
    logic [COL_W-1:0]  beat_addr;
    logic [DATA_W-1:0] arr_word;
    logic              mem_we;

    sdram_col_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (col_cmd_e'(cmd)),
        .col       (col),
        .bl_mode   (burst_len_e'(bl_mode)),
        .issue_rd  (issue_rd),
        .issue_wr  (issue_wr),
        .beat_addr (beat_addr)
    );

    // A masked write word is dropped, the burst still advances
    assign mem_we = issue_wr && !dqm;

    sdram_col_mem #(.DATA_W(DATA_W), .COL_W(COL_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (beat_addr),
        .wdata (wdata),
        .rdata (arr_word)
    );

    sdram_col_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue_rd),
        .rd_word  (arr_word),
        .cas_lat3 (cas_lat3),
        .dqm      (dqm),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: tb/sdram_col_burst_tb.sv
`timescale 1ns/1ps
module sdram_col_burst_tb;
    localparam int DW = 16;
    localparam int CW = 6;
    localparam int NC = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [CW-1:0] col = '0;
    logic          dqm = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [1:0]    bl_mode = 2'b00;
    logic          cas_lat3 = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    always #10 clk = ~clk;

    sdram_col_burst #(.DATA_W(DW), .COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .col(col), .dqm(dqm),
        .wdata(wdata), .bl_mode(bl_mode), .cas_lat3(cas_lat3),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int    checks = 0;
    int    fails = 0;
    int    edge_n = 0;
    string cur_req = "R1";

    logic [DW-1:0] ref_mem [NC];
    logic          exp_v [8];
    logic [DW-1:0] exp_d [8];
    logic          exp_m [8];
    logic          m_act, m_wr, m_page;
    logic [CW-1:0] m_start, m_idx, m_mask;

    function automatic logic [CW-1:0] bl_mask(input logic [1:0] b);
        case (b)
            2'b00:   return CW'(1);
            2'b01:   return CW'(3);
            2'b10:   return CW'(7);
            default: return '1;
        endcase
    endfunction

    function automatic logic [CW-1:0] seq_col(input logic [CW-1:0] s, input logic [CW-1:0] k,
                                              input logic [CW-1:0] msk);
        return (s & ~msk) | ((s + k) & msk);
    endfunction

    task automatic check(input string req, input logic gv, input logic [DW-1:0] gd,
                         input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (gv !== ev || gd !== ed) begin
            fails++;
            $display("FAIL %s edge %0d: got valid=%0b data=%h, expected valid=%0b data=%h",
                     req, edge_n, gv, gd, ev, ed);
        end
    endtask

    // Reference behaviour of one clock edge, using the inputs now driven
    task automatic model_edge();
        logic          iss_r, iss_w;
        logic [CW-1:0] a;
        int            slot;
        iss_r = 1'b0;
        iss_w = 1'b0;
        a     = col;
        case (cmd)
            2'b01, 2'b10: begin
                iss_r   = (cmd == 2'b01);
                iss_w   = (cmd == 2'b10);
                m_act   = 1'b1;
                m_wr    = (cmd == 2'b10);
                m_page  = (bl_mode == 2'b11);
                m_start = col;
                m_mask  = bl_mask(bl_mode);
                m_idx   = CW'(1);
            end
            2'b11: m_act = 1'b0;
            default: begin
                if (m_act) begin
                    a     = seq_col(m_start, m_idx, m_mask);
                    iss_r = !m_wr;
                    iss_w = m_wr;
                    if (!m_page && m_idx == m_mask) m_act = 1'b0;
                    m_idx = m_idx + CW'(1);
                end
            end
        endcase
        if (iss_w && !dqm) ref_mem[a] = wdata;
        if (iss_r) begin
            slot = (edge_n + 1 + int'(cas_lat3)) % 8;
            exp_v[slot] = 1'b1;
            exp_d[slot] = ref_mem[a];
        end
        exp_m[(edge_n + 1) % 8] = dqm;
    endtask

    task automatic step(input logic [1:0] c, input logic [CW-1:0] a, input logic m,
                        input logic [DW-1:0] w);
        int            s;
        logic          ev;
        logic [DW-1:0] ed;
        cmd = c; col = a; dqm = m; wdata = w;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        s  = edge_n % 8;
        ev = exp_v[s] && !exp_m[s];
        ed = ev ? exp_d[s] : '0;
        check(cur_req, rd_valid, rd_data, ev, ed);
        exp_v[s] = 1'b0;
        exp_m[s] = 1'b0;
        edge_n++;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(2'b00, '0, 1'b0, DW'($urandom));
    endtask

    task automatic settle();
        step(2'b11, '0, 1'b0, DW'($urandom));
        nop(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5eed));
        m_act = 0; m_wr = 0; m_page = 0; m_start = '0; m_idx = '0; m_mask = '0;
        for (int i = 0; i < 8; i++) begin exp_v[i] = 0; exp_d[i] = '0; exp_m[i] = 0; end

        // R1: outputs quiet during reset
        repeat (4) begin
            @(negedge clk);
            check("R1", rd_valid, rd_data, 1'b0, '0);
        end
        rst_n = 1'b1;
        cur_req = "R1";
        nop(4);

        // R9: full-page write of the whole array, then two wrapped words
        cur_req = "R9";
        bl_mode = 2'b11;
        step(2'b10, '0, 1'b0, DW'($urandom));
        nop(NC - 1 + 2);
        // R11: stop during write, later data not stored
        cur_req = "R11";
        step(2'b11, '0, 1'b0, DW'($urandom));
        nop(3);
        // R9: full-page read crossing the top column
        cur_req = "R9";
        step(2'b01, CW'(60), 1'b0, '0);
        nop(9);
        // R10: stop on a read
        cur_req = "R10";
        settle();

        // R2: both latencies
        cur_req = "R2";
        bl_mode = 2'b01;
        for (int cl = 0; cl < 2; cl++) begin
            cas_lat3 = cl[0];
            step(2'b01, CW'(16), 1'b0, '0);
            nop(7);
        end
        cas_lat3 = 1'b0;

        // R3: lengths 2, 4, 8
        cur_req = "R3";
        for (int b = 0; b < 3; b++) begin
            bl_mode = b[1:0];
            step(2'b01, CW'(9), 1'b0, '0);
            nop(11);
        end

        // R4: wrap inside the aligned block
        cur_req = "R4";
        bl_mode = 2'b10;
        step(2'b01, CW'(13), 1'b0, '0);
        nop(10);
        bl_mode = 2'b01;
        step(2'b01, CW'(6), 1'b0, '0);
        nop(6);

        // R5: write burst then read it back
        cur_req = "R5";
        step(2'b10, CW'(41), 1'b0, 16'hA5A1);
        nop(4);
        step(2'b01, CW'(40), 1'b0, '0);
        nop(6);

        // R6: read interrupted by a read, latency 3
        cur_req = "R6";
        cas_lat3 = 1'b1;
        bl_mode = 2'b10;
        step(2'b01, CW'(0), 1'b0, '0);
        nop(2);
        step(2'b01, CW'(32), 1'b0, '0);
        nop(11);
        cas_lat3 = 1'b0;

        // R7: write interrupted by a write
        cur_req = "R7";
        bl_mode = 2'b01;
        step(2'b10, CW'(50), 1'b0, 16'h7001);
        step(2'b10, CW'(52), 1'b0, 16'h7002);
        nop(5);
        bl_mode = 2'b10;
        step(2'b01, CW'(48), 1'b0, '0);
        nop(10);

        // R8: read interrupts a write; later write words discarded
        cur_req = "R8";
        step(2'b10, CW'(24), 1'b0, 16'h8001);
        step(2'b01, CW'(28), 1'b0, 16'h8002);
        nop(9);
        step(2'b01, CW'(24), 1'b0, '0);
        nop(10);

        // R10: stop on a full-page read at latency 3
        cur_req = "R10";
        cas_lat3 = 1'b1;
        bl_mode = 2'b11;
        step(2'b01, CW'(10), 1'b0, '0);
        nop(4);
        step(2'b11, '0, 1'b0, '0);
        nop(5);
        cas_lat3 = 1'b0;

        // R12: mask on read output
        cur_req = "R12";
        bl_mode = 2'b10;
        step(2'b01, CW'(0), 1'b0, '0);
        step(2'b00, '0, 1'b0, '0);
        step(2'b00, '0, 1'b1, '0);
        step(2'b00, '0, 1'b0, '0);
        step(2'b00, '0, 1'b0, '0);
        step(2'b00, '0, 1'b1, '0);
        step(2'b00, '0, 1'b1, '0);
        nop(6);

        // R13: mask on a write word
        cur_req = "R13";
        bl_mode = 2'b01;
        step(2'b10, CW'(56), 1'b0, 16'hD001);
        step(2'b00, '0, 1'b1, 16'hD002);
        step(2'b00, '0, 1'b0, 16'hD003);
        step(2'b00, '0, 1'b0, 16'hD004);
        nop(2);
        step(2'b01, CW'(56), 1'b0, '0);
        nop(6);

        // R14: write after read, spaced and immediate
        cur_req = "R14";
        cas_lat3 = 1'b1;
        step(2'b01, CW'(4), 1'b0, '0);
        nop(4);
        step(2'b10, CW'(36), 1'b0, 16'hE001);
        nop(4);
        step(2'b01, CW'(4), 1'b0, '0);
        step(2'b10, CW'(44), 1'b0, 16'hE002);
        nop(4);
        step(2'b01, CW'(36), 1'b0, '0);
        nop(5);
        step(2'b01, CW'(44), 1'b0, '0);
        nop(6);

        // R6 random: mixed commands, modes changed only after a stop
        cur_req = "R6 random";
        for (int i = 0; i < 2400; i++) begin
            int r;
            if (i % 200 == 0) begin
                settle();
                cas_lat3 = 1'($urandom);
                bl_mode = 2'($urandom);
            end
            r = int'($urandom % 16);
            if (r >= 10 && r <= 11)      step(2'b01, CW'($urandom), ($urandom % 8) == 0, DW'($urandom));
            else if (r >= 12 && r <= 13) step(2'b10, CW'($urandom), ($urandom % 8) == 0, DW'($urandom));
            else if (r == 14)            step(2'b11, '0, ($urandom % 8) == 0, DW'($urandom));
            else                         step(2'b00, '0, ($urandom % 8) == 0, DW'($urandom));
        end
        settle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule